// File: doc/BRIEF.md
# Multi-lane link synchronization qualifier

This block decides when a multi-lane serial receive link may be treated as synchronized. Each lane's code-group synchronization logic reports a flag that is high while that lane is in its data phase. The block combines these flags. It moves the link from a waiting state through a qualification state and into a SYNCHRONIZED state, but only after every lane has held data phase without a break for a configurable number of consecutive cycles.

Alongside the link state, the block keeps one saturating frame-alignment error counter per lane. Errors reported while the link is still coming up are discarded at the moment the link qualifies, because they carry no meaning once the link has settled. After that point, errors keep accumulating. When monitoring is active and any lane's count reaches the programmed threshold, a level interrupt is raised so that software can reset the link. A build parameter can restrict monitoring to links that have scrambling enabled.

Top module: `link_sync_qual`

## Requirements
- R1: After reset, and on the cycle after link_en is low, link_state is IDLE (0), every error count is 0 and irq is 0.
- R2: With link_en high, the link goes IDLE (0) to WAIT (1) to QUAL (2). It reaches SYNC (3) on the clock edge at which all lanes have been sampled ready for QUAL_CYCLES consecutive edges, counting the edge that left WAIT. It never reaches SYNC earlier.
- R3: If any lane_ready bit is low while in QUAL, the next state is WAIT and the consecutive count restarts from zero.
- R4: An align_err pulse on a lane whose lane_ready bit is low leaves that lane's count unchanged.
- R5: On the edge that enters SYNC, all error counts are set to 0, which discards errors gathered in WAIT and QUAL.
- R6: Once in SYNC, the link stays in SYNC while link_en is high, even if lane_ready bits drop, and error counts keep incrementing in SYNC.
- R7: With monitoring active, irq goes high one cycle after any lane's count is greater than or equal to a nonzero err_thresh.
- R8: irq stays high until link_en goes low or the counts are cleared on entry to SYNC. This holds even if err_thresh is raised.
- R9: With SCRAM_ONLY set, monitoring is active only when mon_en and scram_en are both 1. While monitoring is inactive, counts do not increment and irq does not rise.
- R10: Each count is ERR_W bits wide and saturates at 2**ERR_W-1 instead of wrapping.
- R11: An err_thresh of 0 never raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en | input | 1 | Link enable; low forces IDLE and clears counts and irq |
| mon_en | input | 1 | Frame-alignment monitoring enable |
| scram_en | input | 1 | Scrambling is on for this link |
| err_thresh | input | ERR_W | Error count that raises irq (0 disables irq) |
| lane_ready | input | NUM_LANES | Per-lane data-phase flag |
| align_err | input | NUM_LANES | Per-lane frame-alignment error pulse |
| link_state | output | 2 | 0 IDLE, 1 WAIT, 2 QUAL, 3 SYNC |
| err_count | output | NUM_LANES*ERR_W | Per-lane counts; lane i is in bits [i*ERR_W +: ERR_W] |
| irq | output | 1 | Alignment-error interrupt, level |

## Verification
If the qualification counter holds a wrong value, link_state reaches SYNC early or late by that error. The bench catches this on the exact edge of entry, because it compares the state every cycle. A counter that is not cleared on a lane drop shows up as an early SYNC during the second qualification attempt. Errors that are mis-gated or a missing clear on SYNC entry appear in err_count on the very next cycle. Wrong interrupt holding shows on irq within one cycle of the threshold crossing, the threshold change or the disable.

// File: rtl/link_sync_pkg.sv
package link_sync_pkg;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_WAIT = 2'd1,
        LS_QUAL = 2'd2,
        LS_SYNC = 2'd3
    } link_state_e;

endpackage

// File: rtl/link_sync_fsm.sv
module link_sync_fsm
    import link_sync_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int QUAL_CYCLES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_en,
    input  logic [NUM_LANES-1:0] lane_ready,
    output link_state_e          state,
    output logic                 qual_done
);
    localparam int QW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;

    typedef struct packed {
        link_state_e   st;
        logic [QW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic all_ready;

    assign all_ready = &lane_ready;

    always_comb begin
        fsm_d     = fsm_q;
        qual_done = 1'b0;
        if (!link_en) begin
            fsm_d.st  = LS_IDLE;
            fsm_d.cnt = '0;
        end else begin
            unique case (fsm_q.st)
                LS_IDLE: fsm_d.st = LS_WAIT;
                LS_WAIT: begin
                    if (all_ready) begin
                        fsm_d.st  = LS_QUAL;
                        fsm_d.cnt = QW'(1);
                    end
                end
                LS_QUAL: begin
                    if (!all_ready) begin
                        fsm_d.st  = LS_WAIT;
                        fsm_d.cnt = '0;
                    end else if (fsm_q.cnt == QW'(QUAL_CYCLES - 1)) begin
                        fsm_d.st  = LS_SYNC;
                        fsm_d.cnt = '0;
                        qual_done = 1'b1;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + QW'(1);
                    end
                end
                LS_SYNC: fsm_d = fsm_q;
                default: fsm_d.st = LS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: LS_IDLE, cnt: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;

    // R1: disable forces idle
    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> state == LS_IDLE);
    // R3: a lane drop during qualification returns to waiting
    p_drop_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == LS_QUAL && !all_ready) |=> state == LS_WAIT);
    // R6: synchronized state is sticky while enabled
    p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == LS_SYNC) |=> state == LS_SYNC);
    // R2: waiting never jumps straight to synchronized
    p_no_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == LS_WAIT |=> state != LS_SYNC);

endmodule

// File: rtl/lane_err_cnt.sv
module lane_err_cnt #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             lane_ready,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ERR_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d.cnt = '0;
        end else if (inc && cnt_q.cnt != CNT_MAX) begin
            cnt_d.cnt = cnt_q.cnt + ERR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;

    // R10: saturation, no wrap
    p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && count == CNT_MAX) |=> count == CNT_MAX);
    // R4: errors from a lane outside data phase are ignored
    p_ignore_unready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !lane_ready) |=> $stable(count));

endmodule

// File: rtl/err_irq.sv
module err_irq #(
    parameter int NUM_LANES = 4,
    parameter int ERR_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       mon_active,
    input  logic [ERR_W-1:0]           thresh,
    input  logic [NUM_LANES*ERR_W-1:0] counts,
    output logic                       irq
);
    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t irq_d, irq_q;
    logic any_hit;

    always_comb begin
        any_hit = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (counts[i*ERR_W +: ERR_W] >= thresh) any_hit = 1'b1;
        end
        irq_d = irq_q;
        if (clear) begin
            irq_d.irq = 1'b0;
        end else if (mon_active && thresh != '0 && any_hit) begin
            irq_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q.irq;

    // R8: level held until cleared
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear) |=> irq);
    // R11: zero threshold never raises the interrupt
    p_zero_thresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && thresh == '0) |=> !irq);
    // R9: inactive monitoring never raises the interrupt
    p_mon_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !mon_active) |=> !irq);

endmodule

// File: rtl/link_sync_qual.sv
module link_sync_qual
    import link_sync_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int QUAL_CYCLES = 256,
    parameter int ERR_W       = 8,
    parameter bit SCRAM_ONLY  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       link_en,
    input  logic                       mon_en,
    input  logic                       scram_en,
    input  logic [ERR_W-1:0]           err_thresh,
    input  logic [NUM_LANES-1:0]       lane_ready,
    input  logic [NUM_LANES-1:0]       align_err,
    output logic [1:0]                 link_state,
    output logic [NUM_LANES*ERR_W-1:0] err_count,
    output logic                       irq
);
    link_state_e state;
    logic        qual_done;
    logic        cnt_clear;
    logic        mon_active;

    generate
        if (SCRAM_ONLY) begin : g_scram_gate
            assign mon_active = mon_en & scram_en;
        end else begin : g_no_gate
            assign mon_active = mon_en;
        end
    endgenerate

    link_sync_fsm #(
        .NUM_LANES  (NUM_LANES),
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en   (link_en),
        .lane_ready(lane_ready),
        .state     (state),
        .qual_done (qual_done)
    );

    assign cnt_clear  = !link_en || qual_done;
    assign link_state = state;

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            lane_err_cnt #(
                .ERR_W(ERR_W)
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (cnt_clear),
                .lane_ready(lane_ready[i]),
                .inc       (align_err[i] & lane_ready[i] & mon_active),
                .count     (err_count[i*ERR_W +: ERR_W])
            );
        end
    endgenerate

    err_irq #(
        .NUM_LANES(NUM_LANES),
        .ERR_W    (ERR_W)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cnt_clear),
        .mon_active(mon_active),
        .thresh    (err_thresh),
        .counts    (err_count),
        .irq       (irq)
    );

    // R5: entry to synchronized state leaves all counts at zero
    p_clear_on_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        qual_done |=> err_count == '0);

endmodule

// File: tb/link_sync_qual_bench.sv
module link_sync_qual_bench;
    localparam int NL    = 4;
    localparam int QC    = 256;
    localparam int EW    = 8;
    localparam int CMAX  = (1 << EW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            link_en = 1'b0;
    logic            mon_en = 1'b0;
    logic            scram_en = 1'b0;
    logic [EW-1:0]   err_thresh = '0;
    logic [NL-1:0]   lane_ready = '0;
    logic [NL-1:0]   align_err = '0;
    logic [1:0]      link_state;
    logic [NL*EW-1:0] err_count;
    logic            irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // expected-item queues
    logic [1:0]       q_st[$];
    logic             q_irq[$];
    logic [NL*EW-1:0] q_cnt[$];
    string            q_tag[$];

    // behavioural expectation state
    int m_st = 0;
    int m_qc = 0;
    int m_err[NL];
    bit m_irq = 1'b0;

    always #4 clk = ~clk;

    link_sync_qual u_link_sync_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en   (link_en),
        .mon_en    (mon_en),
        .scram_en  (scram_en),
        .err_thresh(err_thresh),
        .lane_ready(lane_ready),
        .align_err (align_err),
        .link_state(link_state),
        .err_count (err_count),
        .irq       (irq)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic en, input logic [NL-1:0] rdy, input logic [NL-1:0] er,
                        input logic mon, input logic scr, input int thr, input string tag);
        bit all;
        bit mact;
        bit qd;
        bit hit;
        logic [NL*EW-1:0] flat;
        @(negedge clk);
        link_en    = en;
        lane_ready = rdy;
        align_err  = er;
        mon_en     = mon;
        scram_en   = scr;
        err_thresh = EW'(thr);
        all  = &rdy;
        mact = mon && scr;
        if (!en) begin
            m_st = 0; m_qc = 0; m_irq = 1'b0;
            for (int i = 0; i < NL; i++) m_err[i] = 0;
        end else begin
            qd  = (m_st == 2) && all && (m_qc == QC - 1);
            hit = 1'b0;
            for (int i = 0; i < NL; i++) if (m_err[i] >= thr) hit = 1'b1;
            if (qd) m_irq = 1'b0;
            else if (mact && thr != 0 && hit) m_irq = 1'b1;
            for (int i = 0; i < NL; i++) begin
                if (qd) m_err[i] = 0;
                else if (rdy[i] && er[i] && mact && m_err[i] < CMAX) m_err[i]++;
            end
            case (m_st)
                0: m_st = 1;
                1: if (all) begin m_st = 2; m_qc = 1; end
                2: begin
                    if (!all) begin m_st = 1; m_qc = 0; end
                    else if (m_qc == QC - 1) begin m_st = 3; m_qc = 0; end
                    else m_qc++;
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NL; i++) flat[i*EW +: EW] = EW'(m_err[i]);
        q_st.push_back(2'(m_st));
        q_irq.push_back(m_irq);
        q_cnt.push_back(flat);
        q_tag.push_back(tag);
    endtask

    // monitor: compares each cycle's result after the edge
    always @(posedge clk) begin
        #2;
        if (q_tag.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check(t, "link_state", 64'(link_state), 64'(q_st.pop_front()));
            check(t, "irq", 64'(irq), 64'(q_irq.pop_front()));
            check(t, "err_count", 64'(err_count), 64'(q_cnt.pop_front()));
        end
    end

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) m_err[i] = 0;
        #20;
        // R1: reset state
        check("R1", "reset link_state", 64'(link_state), 64'd0);
        check("R1", "reset err_count", 64'(err_count), 64'd0);
        check("R1", "reset irq", 64'(irq), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: errors on a lane outside data phase are ignored in WAIT
        step(1, 4'b1101, 4'b0000, 1, 1, 200, "R4");
        for (int k = 0; k < 6; k++) step(1, 4'b1101, 4'b0011, 1, 1, 200, "R4");

        // R2: full qualification with errors collected along the way
        for (int k = 0; k < 200; k++)
            step(1, 4'b1111, (k % 3 == 0) ? 4'b0001 : 4'b0000, 1, 1, 200, "R2");
        // R3: a single-cycle lane drop aborts qualification
        step(1, 4'b1011, 4'b0000, 1, 1, 200, "R3");
        step(1, 4'b1011, 4'b0000, 1, 1, 200, "R3");
        // R2/R5: requalify from scratch; SYNC entry clears counts
        for (int k = 0; k < QC + 3; k++)
            step(1, 4'b1111, (k < 10) ? 4'b0100 : 4'b0000, 1, 1, 200, (k < QC - 2) ? "R3" : "R5");

        // R6/R7: errors accumulate in SYNC, lane drop keeps SYNC, irq at threshold
        for (int k = 0; k < 8; k++) step(1, 4'b1110, 4'b1001, 1, 1, 5, "R7");
        step(1, 4'b0000, 4'b0000, 1, 1, 5, "R6");
        // R8: irq held after raising the threshold
        for (int k = 0; k < 5; k++) step(1, 4'b1111, 4'b0000, 1, 1, 250, "R8");
        // R1/R8: disable drops to idle and clears everything
        step(0, 4'b1111, 4'b0000, 1, 1, 250, "R8");
        step(0, 4'b1111, 4'b1111, 1, 1, 250, "R1");

        // R9: scrambling off keeps monitoring inactive
        for (int k = 0; k < QC + 4; k++) step(1, 4'b1111, 4'b1111, 1, 0, 1, "R9");
        for (int k = 0; k < 5; k++) step(1, 4'b1111, 4'b1111, 0, 1, 1, "R9");

        // R10/R11: saturation with zero threshold, irq stays low
        for (int k = 0; k < CMAX + 40; k++) step(1, 4'b1111, 4'b0100, 1, 1, 0, "R10");
        for (int k = 0; k < 4; k++) step(1, 4'b1111, 4'b0100, 1, 1, 0, "R11");

        step(1, 4'b1111, 4'b0000, 1, 1, 0, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule